// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM Pipeline

This block is a single-port synchronous memory with a shared data path. It accepts a fresh read, write or deselect command on every enabled clock edge and needs no idle cycles when switching between reads and writes. Command, address and chip enables are registered on the rising edge. Read data leaves combinationally in the cycle after the edge that took the address. Write data and byte selects are taken one enabled edge later.

A captured write waits in a pending register and is committed to the array on the following enabled edge. Reads of that address merge the pending bytes over the array contents, so any mix of back-to-back reads and writes returns coherent data. An active-low clock enable freezes the whole pipeline, including the pending write. Burst address sequencing and output tristate timing belong to neighbouring blocks. Here a continue cycle repeats the held command at the held address.

Top module: `zt_sram`

## Requirements
- R1: While reset is asserted and after it is released, the block is deselected: `dataValid` is 0, `dataOut` is 0 and no write is pending.
- R2: At an edge with `clkEnN`=0, `advLoad`=0, `ceOneN`=0, `ceTwo`=1, `ceThreeN`=0 and `weN`=1, a read of `addrIn` starts. In the next cycle `dataValid` is 1 and `dataOut` holds that word.
- R3: The same edge with `weN`=0 starts a write. `dataIn` and `byteSelN` are sampled at the next enabled edge, which may carry a new command. Lane i is bits [9i+8:9i] and is written only when `byteSelN[i]`=0. Other lanes keep their contents. During a write `dataValid` is 0.
- R4: A write whose data-phase `byteSelN` is 4'b1111 changes no memory contents.
- R5: An edge with `clkEnN`=1 is ignored. Outputs stay stable and no write is sampled or committed on it.
- R6: An edge with `advLoad`=0 and any chip enable inactive deselects the block, and `dataValid` is 0 in the next cycle. `advLoad`=1 after a deselect keeps the block deselected.
- R7: A read of an address whose write data is not yet committed returns the pending bytes in the lanes it selected and the array bytes in the other lanes.
- R8: An enabled edge with `advLoad`=1 after a read or a write repeats that operation at the held address. A repeated write takes a new data beat at the following edge.
- R9: Reads, writes and deselects can be issued on consecutive enabled edges in any order with no lost or stale data.
- R10: `dataOut` is 0 whenever `dataValid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clkEnN | input | 1 | Active-low clock enable. High stalls the pipeline |
| advLoad | input | 1 | 0 loads a new command, 1 continues the current one |
| ceOneN | input | 1 | Chip enable, active low |
| ceTwo | input | 1 | Chip enable, active high |
| ceThreeN | input | 1 | Chip enable, active low |
| weN | input | 1 | 1 selects a read, 0 selects a write |
| addrIn | input | ADDR_W | Word address |
| byteSelN | input | LANES | Active-low lane write selects, sampled in the data phase |
| dataIn | input | LANES*LANE_W | Write data, sampled one enabled edge after its command |
| dataOut | output | LANES*LANE_W | Read data, 0 when not valid |
| dataValid | output | 1 | High in the cycle after a read command or read continue |

## Verification
A wrong command register shows up in the very next cycle as a wrong `dataValid` level. A misplaced lane, a lost pending write or a missing bypass shows up as a wrong `dataOut` at the first read of the affected address. The bench issues that read immediately after the write and again after the data has been committed, so a fault is seen within one or two cycles. A stall that leaks an update is caught when the released sequence lands different data from the one modelled.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } ztOp_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic step;     // clock edge is enabled
    logic capture;  // sample write data and lane selects on this edge
    logic readOn;   // current cycle presents read data
  } ztStrobe_t;

endpackage

// File: rtl/zt_sram_ctrl.sv
module zt_sram_ctrl
  import zt_sram_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEnN,
  input  logic              advLoad,
  input  logic              ceOneN,
  input  logic              ceTwo,
  input  logic              ceThreeN,
  input  logic              weN,
  input  logic [ADDR_W-1:0] addrIn,
  output ztStrobe_t         strobe,
  output logic [ADDR_W-1:0] curAddr
);

  ztOp_e curOp;
  logic  chipSel;

  assign chipSel = !ceOneN && ceTwo && !ceThreeN;

  // Command register. A continue cycle keeps both the command and the address.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curOp   <= OP_IDLE;
      curAddr <= '0;
    end else if (!clkEnN && !advLoad) begin
      curAddr <= addrIn;
      if (!chipSel)  curOp <= OP_IDLE;
      else if (weN)  curOp <= OP_READ;
      else           curOp <= OP_WRITE;
    end
  end

  always_comb begin
    strobe.step    = !clkEnN;
    strobe.capture = !clkEnN && (curOp == OP_WRITE);
    strobe.readOn  = (curOp == OP_READ);
  end

endmodule

// File: rtl/zt_sram_dp.sv
module zt_sram_dp
  import zt_sram_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ztStrobe_t               strobe,
  input  logic [ADDR_W-1:0]       curAddr,
  input  logic [LANES-1:0]        byteSelN,
  input  logic [LANES*LANE_W-1:0] dataIn,
  output logic [LANES*LANE_W-1:0] dataOut,
  output logic                    dataValid
);

  localparam int WORD_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [WORD_W-1:0] memArr [DEPTH];

  logic              pendValid;
  logic [ADDR_W-1:0] pendAddr;
  logic [WORD_W-1:0] pendData;
  logic [LANES-1:0]  pendMask;
  logic              commitEn;
  logic              pendHit;
  logic [WORD_W-1:0] arrWord;
  logic [WORD_W-1:0] mergedWord;

  assign commitEn = strobe.step && pendValid;

  // Pending write register: filled in the data phase, drained at the next enabled edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      pendAddr  <= '0;
      pendData  <= '0;
      pendMask  <= '0;
    end else if (strobe.step) begin
      pendValid <= strobe.capture;
      if (strobe.capture) begin
        pendAddr <= curAddr;
        pendData <= dataIn;
        pendMask <= ~byteSelN;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (commitEn) begin
      for (int l = 0; l < LANES; l++) begin
        if (pendMask[l]) memArr[pendAddr][l*LANE_W +: LANE_W] <= pendData[l*LANE_W +: LANE_W];
      end
    end
  end

  assign arrWord = memArr[curAddr];
  assign pendHit = pendValid && (pendAddr == curAddr);

  // Per-lane bypass of uncommitted write data
  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign mergedWord[g*LANE_W +: LANE_W] = (pendHit && pendMask[g])
                                          ? pendData[g*LANE_W +: LANE_W]
                                          : arrWord[g*LANE_W +: LANE_W];
  end

  assign dataValid = strobe.readOn;
  assign dataOut   = strobe.readOn ? mergedWord : '0;

endmodule

// File: rtl/zt_sram.sv
module zt_sram
  import zt_sram_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    clkEnN,
  input  logic                    advLoad,
  input  logic                    ceOneN,
  input  logic                    ceTwo,
  input  logic                    ceThreeN,
  input  logic                    weN,
  input  logic [ADDR_W-1:0]       addrIn,
  input  logic [LANES-1:0]        byteSelN,
  input  logic [LANES*LANE_W-1:0] dataIn,
  output logic [LANES*LANE_W-1:0] dataOut,
  output logic                    dataValid
);

  ztStrobe_t         strobe;
  logic [ADDR_W-1:0] curAddr;

  zt_sram_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .clkEnN(clkEnN), .advLoad(advLoad),
    .ceOneN(ceOneN), .ceTwo(ceTwo), .ceThreeN(ceThreeN), .weN(weN),
    .addrIn(addrIn), .strobe(strobe), .curAddr(curAddr)
  );

  zt_sram_dp #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .curAddr(curAddr),
    .byteSelN(byteSelN), .dataIn(dataIn), .dataOut(dataOut), .dataValid(dataValid)
  );

endmodule

// File: rtl/zt_sram_chk.sv
module zt_sram_chk #(
  parameter int WORD_W = 36
) (
  input logic              clk,
  input logic              rstN,
  input logic              clkEnN,
  input logic              advLoad,
  input logic              ceOneN,
  input logic              ceTwo,
  input logic              ceThreeN,
  input logic              weN,
  input logic [WORD_W-1:0] dataOut,
  input logic              dataValid
);

  logic selNow;
  assign selNow = !ceOneN && ceTwo && !ceThreeN;

  always @(negedge clk) begin
    if (!rstN) begin
      p_reset_idle_r1: assert (!dataValid && dataOut == '0);
    end
  end

  p_read_valid_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!clkEnN && !advLoad && selNow && weN) |=> dataValid);

  p_write_quiet_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!clkEnN && !advLoad && selNow && !weN) |=> !dataValid);

  p_stall_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    clkEnN |=> ($stable(dataOut) && $stable(dataValid)));

  p_desel_off_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!clkEnN && !advLoad && !selNow) |=> !dataValid);

  p_out_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    !dataValid |-> (dataOut == '0));

endmodule

bind zt_sram zt_sram_chk #(.WORD_W(LANES*LANE_W)) i_chk (
  .clk(clk), .rstN(rstN), .clkEnN(clkEnN), .advLoad(advLoad),
  .ceOneN(ceOneN), .ceTwo(ceTwo), .ceThreeN(ceThreeN), .weN(weN),
  .dataOut(dataOut), .dataValid(dataValid)
);

// File: tb/test_zt_sram.sv
`timescale 1ns/1ps
module test_zt_sram;

  localparam logic [2:0] SEL = 3'b010;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        clkEnN = 1'b1;
  logic        advLoad = 1'b0;
  logic        ceOneN = 1'b1;
  logic        ceTwo = 1'b0;
  logic        ceThreeN = 1'b1;
  logic        weN = 1'b1;
  logic [3:0]  addrIn = '0;
  logic [3:0]  byteSelN = 4'hF;
  logic [35:0] dataIn = '0;
  logic [35:0] dataOut;
  logic        dataValid;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // Bench reference model
  logic [35:0] expMem [16];
  int          mOp = 0;   // 0 idle, 1 read, 2 write
  logic [3:0]  mAddr = '0;

  always #2.5 clk = ~clk;

  zt_sram i_zt_sram (
    .clk(clk), .rstN(rstN), .clkEnN(clkEnN), .advLoad(advLoad),
    .ceOneN(ceOneN), .ceTwo(ceTwo), .ceThreeN(ceThreeN), .weN(weN),
    .addrIn(addrIn), .byteSelN(byteSelN), .dataIn(dataIn),
    .dataOut(dataOut), .dataValid(dataValid)
  );

  function automatic logic [35:0] pat(input int a, input int salt);
    logic [63:0] v;
    v = 64'(a + 1) * 64'h9E3779B97 + 64'(salt) * 64'h5BD1E995;
    return v[35:0] ^ v[63:28];
  endfunction

  task automatic check(input string tag, input logic v, input logic [35:0] o,
                       input logic ev, input logic [35:0] eo);
    total++;
    if (v !== ev || o !== eo) begin
      bad++;
      $display("FAIL %s: valid=%0b out=%h expected valid=%0b out=%h", tag, v, o, ev, eo);
    end
  endtask

  // Drive one clock's worth of inputs at a falling edge, advance to the next
  // falling edge and compare the outputs against the model.
  task automatic step(input logic cen, input logic adv, input logic [2:0] ce,
                      input logic we, input int a, input logic [3:0] bs,
                      input logic [35:0] d, input string tag);
    logic ev;
    logic [35:0] eo;
    clkEnN = cen; advLoad = adv; {ceOneN, ceTwo, ceThreeN} = ce;
    weN = we; addrIn = 4'(a); byteSelN = bs; dataIn = d;
    if (!cen) begin
      if (mOp == 2) begin
        for (int l = 0; l < 4; l++)
          if (!bs[l]) expMem[mAddr][l*9 +: 9] = d[l*9 +: 9];
      end
      if (!adv) begin
        mAddr = 4'(a);
        if (ce != SEL) mOp = 0;
        else mOp = we ? 1 : 2;
      end
    end
    @(negedge clk);
    ev = (mOp == 1);
    eo = ev ? expMem[mAddr] : 36'h0;
    check(tag, dataValid, dataOut, ev, eo);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL R9: watchdog expired, actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [35:0] prev;
    for (int i = 0; i < 16; i++) expMem[i] = '0;
    repeat (3) @(negedge clk);
    check("R1", dataValid, dataOut, 1'b0, 36'h0);  // R1 during reset
    rstN = 1'b1;
    @(negedge clk);
    check("R1", dataValid, dataOut, 1'b0, 36'h0);  // R1 after release

    // R3: fill every address, write data follows one edge later (R9 back to back)
    prev = '0;
    for (int a = 0; a < 16; a++) begin
      step(0, 0, SEL, 0, a, 4'h0, prev, "R3");
      prev = pat(a, 1);
    end
    step(0, 0, SEL, 1, 0, 4'h0, prev, "R9");
    // R2: read every address back to back
    for (int a = 1; a < 16; a++) step(0, 0, SEL, 1, a, 4'hF, 36'h0, "R2");

    // R7/R3/R4: each lane-select pattern, read issued on the data edge
    for (int m = 0; m < 16; m++) begin
      step(0, 0, SEL, 0, 5, 4'hF, 36'h0, "R3");
      step(0, 0, SEL, 1, 5, 4'(m), pat(m, 9), (m == 15) ? "R4" : "R7");
    end
    // R4: abort, then read after the pending slot has drained
    step(0, 0, SEL, 0, 11, 4'hF, 36'h0, "R4");
    step(0, 0, 3'b110, 1, 0, 4'hF, pat(0, 77), "R4");
    step(0, 0, SEL, 1, 11, 4'h0, 36'h0, "R4");
    step(0, 0, SEL, 1, 11, 4'h0, 36'h0, "R4");

    // R5: stall between a write command and its data beat
    step(0, 0, SEL, 0, 7, 4'hF, 36'h0, "R5");
    step(1, 0, SEL, 1, 3, 4'h0, pat(7, 66), "R5");
    step(1, 0, SEL, 1, 3, 4'h0, pat(7, 67), "R5");
    step(0, 0, SEL, 1, 7, 4'h3, pat(7, 5), "R5");
    step(1, 0, SEL, 0, 2, 4'h0, pat(2, 66), "R5");
    step(1, 1, SEL, 0, 2, 4'h0, pat(2, 66), "R5");
    step(0, 0, SEL, 1, 2, 4'h0, 36'h0, "R5");

    // R6: each chip enable on its own deselects, continue keeps it deselected
    for (int c = 0; c < 3; c++) begin
      step(0, 0, SEL, 1, c + 1, 4'hF, 36'h0, "R2");
      step(0, 0, SEL ^ (3'b100 >> c), 1, c + 4, 4'hF, 36'h0, "R6");
      step(0, 1, SEL, 1, c + 4, 4'hF, 36'h0, "R6");
    end
    // R6: write data beat still lands when the next edge deselects
    step(0, 0, SEL, 0, 12, 4'hF, 36'h0, "R6");
    step(0, 0, 3'b011, 1, 0, 4'h5, pat(12, 3), "R6");
    step(0, 0, SEL, 1, 12, 4'hF, 36'h0, "R6");

    // R8: read continue and write continue at the held address
    step(0, 0, SEL, 1, 2, 4'hF, 36'h0, "R8");
    step(0, 1, 3'b111, 0, 9, 4'h0, 36'h0, "R8");
    step(0, 1, 3'b111, 0, 9, 4'h0, 36'h0, "R8");
    step(0, 0, SEL, 0, 9, 4'hF, 36'h0, "R8");
    step(0, 1, 3'b111, 1, 0, 4'h0, pat(9, 1), "R8");
    step(0, 0, SEL, 1, 9, 4'hC, pat(9, 2), "R8");

    // R9/R10: mixed read/write/deselect stream
    for (int i = 0; i < 96; i++) begin
      int op;
      int a;
      op = (i * 5 + i / 7) % 3;
      a = (i * 7 + 3) % 16;
      if (op == 0) step(0, 0, SEL, 1, a, 4'(i), pat(i, 40), "R9");
      else if (op == 1) step(0, 0, SEL, 0, a, 4'(i), pat(i, 41), "R10");
      else step(0, 0, 3'b000, 1, a, 4'(i * 3), pat(i, 42), "R10");
    end
    // R2: final read-back sweep of all contents
    for (int a = 0; a < 16; a++) step(0, 0, SEL, 1, a, 4'hF, 36'h0, "R2");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule